// File: doc/BRIEF.md
# Watchdog and Clock-Monitor Reset Generator

This block raises system reset requests from two independent supervisors. The first is a software watchdog. It counts slow ticks derived from the block clock. A fixed power-of-two prescaler first divides that clock, and a selectable post-divider of 1, 2 or 4 then divides it again. If software does not write the two-byte service key in time, the counter rolls over from its all-ones value and the watchdog requests a reset.

The second supervisor is a clock monitor. It samples an external monitored clock through a synchronizer and watches it for transitions. If a full window of block-clock cycles passes with no transition, it requests a reset. The block clock acts as the reference clock, and it is independent of the monitored clock.

Each cause has its own output line, so the downstream reset resolver can choose the matching reset vector. Every request is stretched to a fixed minimum length. A cause register holds the supervisor that fired most recently, and the power-on reset clears it.

Top module: `rstgen_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_wd` and `req_cm` are low and `cause` reads 0 (none).
- R2: While `wd_en` is low, the watchdog never asserts `req_wd`, whatever is written to the service port.
- R3: With `wd_en` high, `req_wd` rises after exactly 2^PRE_BITS × D × 2^CNT_W clock edges, counted from the first edge at which the enable is sampled high. D is 1 for `wd_rate`=0, 2 for `wd_rate`=1 and 4 for `wd_rate`=2 or 3.
- R4: A service write of 0x55 followed by a write of 0xAA on the next service strobe restarts the whole timeout at the 0xAA edge. The request then comes a full period after that edge.
- R5: Any other write sequence does not restart the timeout. This includes 0xAA without a preceding 0x55, and 0x55 followed by a different byte and then 0xAA.
- R6: While `cm_en` is low, the clock monitor never asserts `req_cm`.
- R7: With `cm_en` high, `req_cm` rises after WIN consecutive clock edges in which no synchronized transition of `mon_clk` is seen. A monitored clock that toggles more often than once per window never triggers it.
- R8: Each request line stays high for exactly HOLD cycles after it rises, unless a new event of the same kind extends it.
- R9: `cause` reads 1 after a watchdog request and 2 after a clock-monitor request. It always holds the most recent cause, and the value 3 never appears.
- R10: A clock-monitor event takes priority. When both supervisors fire on the same edge, or while `req_cm` is high, the watchdog event is absorbed. `req_wd` stays low and `cause` reads 2. The two request lines are never high together.
- R11: The watchdog counter runs freely. Without service, a second `req_wd` rises exactly one full period after the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the reference clock for the clock monitor |
| rst | input | 1 | Synchronous active-high power-on reset |
| wd_en | input | 1 | Watchdog enable |
| wd_rate | input | 2 | Watchdog post-divider select (0: /1, 1: /2, 2 or 3: /4) |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service byte |
| cm_en | input | 1 | Clock-monitor enable |
| mon_clk | input | 1 | Monitored clock, asynchronous to `clk` |
| req_wd | output | 1 | Watchdog reset request, stretched |
| req_cm | output | 1 | Clock-monitor reset request, stretched |
| cause | output | 2 | Last cause: 0 none, 1 watchdog, 2 clock monitor |

## Verification
The bench builds the block with PRE_BITS=2, CNT_W=4, WIN=64 and HOLD=4. With these values one watchdog period at divide-by-1 is 64 edges. That puts all four rate settings, the free-running second rollover and the service-key restarts within a few hundred cycles. Because WIN is also 64, both supervisors can be made to fire on the same edge, which exercises the priority rule directly. A HOLD of 4 keeps the exact-length check on the stretched requests short.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_WDOG   = 2'd1,
    CAUSE_CLKMON = 2'd2
  } cause_e;

  localparam logic [7:0] SVC_KEY_FIRST  = 8'h55;
  localparam logic [7:0] SVC_KEY_SECOND = 8'hAA;
endpackage

// File: rtl/rg_prescaler.sv
module rg_prescaler #(
  parameter int PRE_BITS = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] rate_sel,
  output logic       tick
);
  logic [PRE_BITS-1:0] pre_q;
  logic [1:0]          post_q;
  logic [1:0]          post_mask;
  logic                base_tick;

  assign base_tick = run && (&pre_q);

  always_comb begin
    case (rate_sel)
      2'd0:    post_mask = 2'b00;
      2'd1:    post_mask = 2'b01;
      default: post_mask = 2'b11;
    endcase
  end

  assign tick = base_tick && ((post_q & post_mask) == post_mask);

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_BITS'(1);
      if (base_tick) post_q <= post_q + 2'd1;
    end
  end
endmodule

// File: rtl/rg_watchdog.sv
module rg_watchdog
  import rstgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       restart,
  output logic       fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign restart = en && svc_wr && armed_q && (svc_data == SVC_KEY_SECOND);
  assign fire    = en && tick && (&cnt_q) && !restart;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed_q <= 1'b0;
    end else if (svc_wr) begin
      armed_q <= (svc_data == SVC_KEY_FIRST);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rg_clkmon.sv
module rg_clkmon #(
  parameter int WIN         = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic mon_clk,
  output logic fire
);
  localparam int CW = $clog2(WIN) + 1;

  logic [SYNC_STAGES:0] sh_q;
  logic                 edge_seen;
  logic [CW-1:0]        cnt_q;
  logic                 at_limit;

  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sh_q[0] <= 1'b0;
          else     sh_q[0] <= mon_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sh_q[g] <= 1'b0;
          else     sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_seen = sh_q[SYNC_STAGES] ^ sh_q[SYNC_STAGES-1];
  assign at_limit  = (cnt_q == CW'(WIN - 1));
  assign fire      = en && !edge_seen && at_limit;

  always_ff @(posedge clk) begin
    if (rst || !en || edge_seen || at_limit) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rg_stretch.sv
module rg_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clear,
  output logic active
);
  localparam int HW = $clog2(HOLD) + 1;

  logic [HW-1:0] cnt_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (load) begin
      cnt_q <= HW'(HOLD - 1);
      act_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - HW'(1);
    end else begin
      act_q <= 1'b0;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top
  import rstgen_pkg::*;
#(
  parameter int PRE_BITS    = 15,
  parameter int CNT_W       = 16,
  parameter int WIN         = 256,
  parameter int HOLD        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wd_en,
  input  logic [1:0] wd_rate,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  input  logic       cm_en,
  input  logic       mon_clk,
  output logic       req_wd,
  output logic       req_cm,
  output logic [1:0] cause
);
  logic   wd_tick;
  logic   wd_restart;
  logic   wd_fire;
  logic   cm_fire;
  logic   wd_load;
  cause_e cause_q;

  rg_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (wd_en),
    .restart  (wd_restart),
    .rate_sel (wd_rate),
    .tick     (wd_tick)
  );

  rg_watchdog #(.CNT_W(CNT_W)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .en       (wd_en),
    .tick     (wd_tick),
    .svc_wr   (svc_wr),
    .svc_data (svc_data),
    .restart  (wd_restart),
    .fire     (wd_fire)
  );

  rg_clkmon #(.WIN(WIN), .SYNC_STAGES(SYNC_STAGES)) u_cmon (
    .clk     (clk),
    .rst     (rst),
    .en      (cm_en),
    .mon_clk (mon_clk),
    .fire    (cm_fire)
  );

  // A pending clock-monitor request absorbs any watchdog event.
  assign wd_load = wd_fire && !cm_fire && !req_cm;

  rg_stretch #(.HOLD(HOLD)) u_hold_cm (
    .clk    (clk),
    .rst    (rst),
    .load   (cm_fire),
    .clear  (1'b0),
    .active (req_cm)
  );

  rg_stretch #(.HOLD(HOLD)) u_hold_wd (
    .clk    (clk),
    .rst    (rst),
    .load   (wd_load),
    .clear  (cm_fire),
    .active (req_wd)
  );

  always_ff @(posedge clk) begin
    if (rst)          cause_q <= CAUSE_NONE;
    else if (cm_fire) cause_q <= CAUSE_CLKMON;
    else if (wd_load) cause_q <= CAUSE_WDOG;
  end

  assign cause = cause_q;
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk (
  input logic       clk,
  input logic       rst,
  input logic       wd_en,
  input logic       cm_en,
  input logic       req_wd,
  input logic       req_cm,
  input logic [1:0] cause
);
  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst) !(req_wd && req_cm));

  // R9
  cause_legal_chk: assert property (@(posedge clk) disable iff (rst) cause != 2'd3);

  // R2
  wd_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!wd_en && !req_wd) |=> !req_wd);

  // R6
  cm_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!cm_en && !req_cm) |=> !req_cm);

  // R9
  cause_cm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_cm) |-> cause == 2'd2);

  // R9
  cause_wd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_wd) |-> cause == 2'd1);

  // R8
  hold_cm_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_cm) |=> req_cm);

  // R8
  hold_wd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_wd) |=> (req_wd || req_cm));
endmodule

bind rstgen_top rstgen_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .wd_en  (wd_en),
  .cm_en  (cm_en),
  .req_wd (req_wd),
  .req_cm (req_cm),
  .cause  (cause)
);

// File: tb/tb_rstgen_top.sv
`timescale 1ns/1ps
module tb_rstgen_top;
  localparam int PRE_BITS = 2;
  localparam int CNT_W    = 4;
  localparam int WIN      = 64;
  localparam int HOLD     = 4;
  localparam int BASE     = (1 << PRE_BITS) * (1 << CNT_W);
  localparam int NVEC     = 4;

  localparam logic [1:0] VEC_RATE [NVEC] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam int         VEC_EXP  [NVEC] = '{BASE, 2*BASE, 4*BASE, 4*BASE};

  logic       clk = 1'b0;
  logic       rst;
  logic       wd_en;
  logic [1:0] wd_rate;
  logic       svc_wr;
  logic [7:0] svc_data;
  logic       cm_en;
  logic       mon_clk;
  logic       req_wd;
  logic       req_cm;
  logic [1:0] cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rstgen_top #(
    .PRE_BITS(PRE_BITS), .CNT_W(CNT_W), .WIN(WIN), .HOLD(HOLD)
  ) dut (
    .clk(clk), .rst(rst), .wd_en(wd_en), .wd_rate(wd_rate),
    .svc_wr(svc_wr), .svc_data(svc_data), .cm_en(cm_en),
    .mon_clk(mon_clk), .req_wd(req_wd), .req_cm(req_cm), .cause(cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wd_en = 1'b0; wd_rate = 2'd0; svc_wr = 1'b0;
    svc_data = 8'h00; cm_en = 1'b0; mon_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic svc(input logic [7:0] b);
    svc_wr = 1'b1; svc_data = b;
    @(negedge clk);
    svc_wr = 1'b0; svc_data = 8'h00;
  endtask

  task automatic wait_rise(input bit sel_cm, input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk);
      n++;
      if (sel_cm ? req_cm : req_wd) break;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog-expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int m;
    int bad;

    // R1: reset state
    do_reset();
    @(negedge clk);
    chk("R1 req_wd", req_wd, 0);
    chk("R1 req_cm", req_cm, 0);
    chk("R1 cause", cause, 0);

    // R3 / R8 / R9: rate vectors
    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      wd_rate = VEC_RATE[i];
      wd_en   = 1'b1;
      wait_rise(1'b0, 2000, n);
      chk($sformatf("R3 rate=%0d edges", VEC_RATE[i]), n, VEC_EXP[i]);
      chk("R9 cause after watchdog", cause, 1);
      m = 1;
      while (m < 100) begin
        @(negedge clk);
        if (!req_wd) break;
        m++;
      end
      chk("R8 watchdog hold length", m, HOLD);
    end

    // R11: second rollover without service
    do_reset();
    wd_en = 1'b1;
    wait_rise(1'b0, 2000, n);
    m = 0;
    while (m < 100) begin
      @(negedge clk);
      m++;
      if (!req_wd) break;
    end
    wait_rise(1'b0, 2000, n);
    chk("R11 second period", m + n, BASE);

    // R4: valid service restarts the timeout
    do_reset();
    wd_en = 1'b1;
    repeat (40) @(negedge clk);
    svc(8'h55);
    svc(8'hAA);
    wait_rise(1'b0, 2000, n);
    chk("R4 edges after service", n, BASE);

    // R5: broken sequences do not restart
    do_reset();
    wd_en = 1'b1;
    repeat (10) @(negedge clk);
    svc(8'hAA);
    svc(8'h55);
    svc(8'h12);
    svc(8'hAA);
    wait_rise(1'b0, 2000, n);
    chk("R5 edges after bad service", n, BASE - 14);

    // R2: watchdog disabled, writes ignored
    do_reset();
    bad = 0;
    for (int k = 0; k < 600; k++) begin
      if (k == 100) svc(8'h55);
      else if (k == 101) svc(8'hAA);
      else @(negedge clk);
      if (req_wd) bad++;
    end
    chk("R2 req_wd while disabled", bad, 0);

    // R6: clock monitor disabled with a dead clock
    do_reset();
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (req_cm) bad++;
    end
    chk("R6 req_cm while disabled", bad, 0);

    // R7: dead monitored clock fires after WIN edges
    do_reset();
    cm_en = 1'b1;
    wait_rise(1'b1, 2000, n);
    chk("R7 edges to clock-monitor request", n, WIN);
    chk("R9 cause after clock monitor", cause, 2);
    m = 1;
    while (m < 100) begin
      @(negedge clk);
      if (!req_cm) break;
      m++;
    end
    chk("R8 clock-monitor hold length", m, HOLD);

    // R1: reset clears recorded cause
    do_reset();
    @(negedge clk);
    chk("R1 cause cleared by reset", cause, 0);

    // R7: a toggling monitored clock never fires
    cm_en = 1'b1;
    bad = 0;
    for (int k = 0; k < 400; k++) begin
      if (k % (WIN / 2) == WIN / 2 - 1) mon_clk = ~mon_clk;
      @(negedge clk);
      if (req_cm) bad++;
    end
    chk("R7 live clock no request", bad, 0);

    // R9: most recent cause is kept
    do_reset();
    cm_en = 1'b1;
    wait_rise(1'b1, 2000, n);
    cm_en = 1'b0;
    wd_en = 1'b1;
    wait_rise(1'b0, 2000, n);
    chk("R9 watchdog after clock monitor edges", n, BASE);
    chk("R9 cause overwritten", cause, 1);

    // R10: coincident events, clock monitor wins
    do_reset();
    wd_en = 1'b1;
    cm_en = 1'b1;
    wait_rise(1'b1, 2000, n);
    chk("R10 clock-monitor edges", n, WIN);
    chk("R10 req_wd suppressed", req_wd, 0);
    chk("R10 cause", cause, 2);
    bad = 0;
    for (int k = 0; k < HOLD; k++) begin
      @(negedge clk);
      if (req_wd) bad++;
    end
    chk("R10 req_wd stays low during hold", bad, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule